// File: doc/BRIEF.md
# Auto-Negotiation Duplex Resolver over a PHY Management Read Port

This block keeps the duplex setting of a two-port switch in step with what its PHYs have negotiated. It polls the PHYs one after the other through a command-level management read port. Each read is a request/acknowledge exchange that carries a PHY address and a register address and returns a 16-bit word. The serial clocking of the management bus sits outside the block.

On every poll the block reads the basic status register of one PHY. From that word it takes the link-up bit and the auto-negotiation-done bit. While negotiation is not done, the port is held at half duplex. When the done bit goes from 0 to 1, the block reads the local advertisement register and then the partner ability register of that PHY. It picks the best ability that both sides offer, and sets the port's duplex output to full only when that ability is a full-duplex one. After this resolve sequence, round-robin polling of the status registers resumes.

The whole function is switched on by two strap inputs. They are sampled while reset is high.

Top module: `mdio_duplex_resolver`

## Requirements
- R1: The block is enabled only if both strap bits are 1 while reset is high. When it is disabled, rd_req stays 0 and every duplex and link output stays 0. After reset all outputs are 0.
- R2: Only reads are issued, to register addresses 1, 4 or 5. Reads of register 1 alternate between PHY address 1 (port 0) and PHY address 2 (port 1).
- R3: A register 1 read whose bit 5 (negotiation done) is 0 sets that port's duplex_full to 0 in the following cycle.
- R4: Each register 1 read copies bit 2 (link up) into that port's link_up output in the following cycle, whatever the value of bit 5.
- R5: When a port's register 1 bit 5 is read as 1 and the previous read of that port returned 0, the next two reads are register 4 and then register 5 of the same PHY. After them, polling moves on to the register 1 read of the other port.
- R6: While bit 5 is still read as 1 on every read, that port gets no further register 4 or register 5 reads.
- R7: If the first register 1 read of a port after reset returns bit 5 = 1, the resolve sequence of R5 runs once for that port.
- R8: The common ability is register 4 AND register 5, bits 9..6. The first match in this order wins: bit 8 (100BASE-TX full), bit 9 (100BASE-T4), bit 7 (100BASE-TX half), bit 6 (10BASE-T full). If none match, the result is 10BASE-T half.
- R9: duplex_full becomes 1 only when the resolved ability is 100BASE-TX full or 10BASE-T full. A port's duplex_full changes only in the cycle after a register 5 read or a register 1 read of that port has completed.
- R10: rd_req stays asserted with rd_phy and rd_reg held steady until rd_ack. Only one read is outstanding at a time.
- R11: Each port keeps its own done-bit history, link and duplex. Traffic on one port never changes the outputs of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while it is high |
| strap_en | input | 2 | Enable straps; both must be 1 at reset |
| rd_req | output | 1 | Read request to the management master |
| rd_phy | output | 5 | PHY address of the pending read |
| rd_reg | output | 5 | Register address of the pending read |
| rd_ack | input | 1 | One-cycle completion pulse for the pending read |
| rd_data | input | 16 | Read data, valid with rd_ack |
| duplex_full | output | 2 | Per-port duplex, 1 = full |
| link_up | output | 2 | Per-port latched link status |

## Verification
The assertions assume the management master raises rd_ack for one cycle only while rd_req is high, with rd_data valid in that same cycle. They also assume that a read's address never changes under the master. The bench's responder waits zero to two cycles before it acknowledges a read, drops rd_ack in the next cycle, and checks that the address stayed put while the read was pending. PHY register contents change only between responses, so every returned word is one consistent snapshot.

// File: rtl/mdr_pkg.sv
package mdr_pkg;

    localparam int unsigned DATA_W  = 16;
    localparam int unsigned ADDR_W  = 5;

    localparam logic [ADDR_W-1:0] REG_STAT = 5'd1;
    localparam logic [ADDR_W-1:0] REG_ADV  = 5'd4;
    localparam logic [ADDR_W-1:0] REG_LPA  = 5'd5;

    localparam int unsigned BIT_LINK   = 2;
    localparam int unsigned BIT_ANDONE = 5;
    localparam int unsigned ABIL_LSB   = 6;
    localparam int unsigned ABIL_W     = 4;

    // positions inside the 4-bit ability field (register bits 9..6)
    localparam int unsigned AF_10FD = 0;
    localparam int unsigned AF_TXHD = 1;
    localparam int unsigned AF_TXFD = 2;
    localparam int unsigned AF_T4   = 3;

    typedef enum logic [1:0] {
        PS_STAT = 2'd0,
        PS_ADV  = 2'd1,
        PS_LPA  = 2'd2
    } poll_state_e;

    typedef enum logic [2:0] {
        AB_10HD = 3'd0,
        AB_10FD = 3'd1,
        AB_TXHD = 3'd2,
        AB_T4   = 3'd3,
        AB_TXFD = 3'd4
    } ability_e;

    typedef struct packed {
        logic prev_done;
        logic link;
        logic full;
    } port_ctx_t;

    function automatic ability_e pick_ability(input logic [ABIL_W-1:0] adv,
                                              input logic [ABIL_W-1:0] lpa);
        logic [ABIL_W-1:0] both;
        both = adv & lpa;
        if (both[AF_TXFD])      return AB_TXFD;
        else if (both[AF_T4])   return AB_T4;
        else if (both[AF_TXHD]) return AB_TXHD;
        else if (both[AF_10FD]) return AB_10FD;
        else                    return AB_10HD;
    endfunction

    function automatic logic ability_full(input ability_e ab);
        return (ab == AB_TXFD) || (ab == AB_10FD);
    endfunction

endpackage

// File: rtl/mdr_ability_resolve.sv
module mdr_ability_resolve
    import mdr_pkg::*;
(
    input  logic [ABIL_W-1:0] adv_field,
    input  logic [ABIL_W-1:0] lpa_field,
    output logic              res_full
);

    ability_e ability;

    always_comb begin
        ability  = pick_ability(adv_field, lpa_field);
        res_full = ability_full(ability);
    end

endmodule

// File: rtl/mdr_poll_fsm.sv
module mdr_poll_fsm
    import mdr_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int PHY_BASE  = 1,
    parameter int PORT_W    = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                active,
    input  logic                rd_ack,
    input  logic                done_bit,
    input  logic [ABIL_W-1:0]   abil_in,
    input  logic                sel_prev_done,
    output logic                rd_req,
    output logic [ADDR_W-1:0]   rd_phy,
    output logic [ADDR_W-1:0]   rd_reg,
    output logic [PORT_W-1:0]   port_idx,
    output logic                stat_ev,
    output logic                res_ev,
    output logic [ABIL_W-1:0]   adv_q
);

    localparam logic [PORT_W-1:0] LAST_PORT = PORT_W'(NUM_PORTS - 1);

    poll_state_e       st_q;
    logic [PORT_W-1:0] port_q;
    logic [PORT_W-1:0] port_nxt;
    logic              take;

    assign take     = active && rd_ack;
    assign port_nxt = (port_q == LAST_PORT) ? '0 : port_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= PS_STAT;
            port_q <= '0;
            adv_q  <= '0;
        end else if (take) begin
            case (st_q)
                PS_STAT: begin
                    if (done_bit && !sel_prev_done) st_q <= PS_ADV;
                    else                            port_q <= port_nxt;
                end
                PS_ADV: begin
                    adv_q <= abil_in;
                    st_q  <= PS_LPA;
                end
                PS_LPA: begin
                    st_q   <= PS_STAT;
                    port_q <= port_nxt;
                end
                default: st_q <= PS_STAT;
            endcase
        end
    end

    always_comb begin
        rd_req   = active;
        rd_phy   = ADDR_W'(PHY_BASE) + ADDR_W'(port_q);
        port_idx = port_q;
        stat_ev  = take && (st_q == PS_STAT);
        res_ev   = take && (st_q == PS_LPA);
        case (st_q)
            PS_ADV:  rd_reg = REG_ADV;
            PS_LPA:  rd_reg = REG_LPA;
            default: rd_reg = REG_STAT;
        endcase
    end

endmodule

// File: rtl/mdr_port_ctx.sv
module mdr_port_ctx
    import mdr_pkg::*;
#(
    parameter int PORT_W  = 1,
    parameter int PORT_ID = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PORT_W-1:0] port_idx,
    input  logic              stat_ev,
    input  logic              res_ev,
    input  logic              done_bit,
    input  logic              link_bit,
    input  logic              res_full,
    output port_ctx_t         ctx
);

    logic mine;
    assign mine = (port_idx == PORT_W'(PORT_ID));

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx <= '0;
        end else if (mine && stat_ev) begin
            ctx.prev_done <= done_bit;
            ctx.link      <= link_bit;
            if (!done_bit) ctx.full <= 1'b0;
        end else if (mine && res_ev) begin
            ctx.full <= res_full;
        end
    end

endmodule

// File: rtl/mdio_duplex_resolver.sv
module mdio_duplex_resolver
    import mdr_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int PHY_BASE  = 1,
    parameter int STRAP_W   = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [STRAP_W-1:0]   strap_en,
    output logic                 rd_req,
    output logic [4:0]           rd_phy,
    output logic [4:0]           rd_reg,
    input  logic                 rd_ack,
    input  logic [15:0]          rd_data,
    output logic [NUM_PORTS-1:0] duplex_full,
    output logic [NUM_PORTS-1:0] link_up
);

    localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

    logic                  en_q;
    logic                  active_q;
    logic [PORT_W-1:0]     port_idx;
    logic                  stat_ev;
    logic                  res_ev;
    logic [ABIL_W-1:0]     adv_q;
    logic                  res_full;
    logic [NUM_PORTS-1:0]  prev_vec;
    port_ctx_t             ctx [NUM_PORTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= &strap_en;
            active_q <= 1'b0;
        end else begin
            active_q <= en_q;
        end
    end

    mdr_poll_fsm #(
        .NUM_PORTS (NUM_PORTS),
        .PHY_BASE  (PHY_BASE),
        .PORT_W    (PORT_W)
    ) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .active        (active_q),
        .rd_ack        (rd_ack),
        .done_bit      (rd_data[BIT_ANDONE]),
        .abil_in       (rd_data[ABIL_LSB +: ABIL_W]),
        .sel_prev_done (prev_vec[port_idx]),
        .rd_req        (rd_req),
        .rd_phy        (rd_phy),
        .rd_reg        (rd_reg),
        .port_idx      (port_idx),
        .stat_ev       (stat_ev),
        .res_ev        (res_ev),
        .adv_q         (adv_q)
    );

    mdr_ability_resolve u_res (
        .adv_field (adv_q),
        .lpa_field (rd_data[ABIL_LSB +: ABIL_W]),
        .res_full  (res_full)
    );

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        mdr_port_ctx #(
            .PORT_W  (PORT_W),
            .PORT_ID (g)
        ) u_ctx (
            .clk      (clk),
            .rst      (rst),
            .port_idx (port_idx),
            .stat_ev  (stat_ev),
            .res_ev   (res_ev),
            .done_bit (rd_data[BIT_ANDONE]),
            .link_bit (rd_data[BIT_LINK]),
            .res_full (res_full),
            .ctx      (ctx[g])
        );
        assign prev_vec[g]    = ctx[g].prev_done;
        assign duplex_full[g] = ctx[g].full;
        assign link_up[g]     = ctx[g].link;
    end

endmodule

// File: rtl/mdr_checker.sv
module mdr_checker #(
    parameter int NUM_PORTS = 2,
    parameter int PHY_BASE  = 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 en_q,
    input logic                 rd_req,
    input logic [4:0]           rd_phy,
    input logic [4:0]           rd_reg,
    input logic                 rd_ack,
    input logic [15:0]          rd_data,
    input logic [NUM_PORTS-1:0] duplex_full,
    input logic [NUM_PORTS-1:0] link_up
);

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> !rd_req); // R1

    AST_PHY_RANGE: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (rd_phy >= 5'(PHY_BASE)) && (rd_phy < 5'(PHY_BASE + NUM_PORTS))); // R2

    AST_REG_SET: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (rd_reg == 5'd1) || (rd_reg == 5'd4) || (rd_reg == 5'd5)); // R2

    AST_HOLD_REQ: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> rd_req && $stable(rd_phy) && $stable(rd_reg)); // R10

    AST_ADV_THEN_LPA: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_ack && rd_reg == 5'd4) |=> rd_req && rd_reg == 5'd5 && $stable(rd_phy)); // R5

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_chk
        AST_HALF_ON_OPEN: assert property (@(posedge clk) disable iff (rst)
            (rd_req && rd_ack && rd_reg == 5'd1 && rd_phy == 5'(PHY_BASE + g) && !rd_data[5])
            |=> !duplex_full[g]); // R3

        AST_LINK_LATCH: assert property (@(posedge clk) disable iff (rst)
            (rd_req && rd_ack && rd_reg == 5'd1 && rd_phy == 5'(PHY_BASE + g))
            |=> link_up[g] == $past(rd_data[2])); // R4

        AST_DUPLEX_SOURCE: assert property (@(posedge clk) disable iff (rst)
            !$stable(duplex_full[g]) |->
            $past(rd_req && rd_ack && rd_phy == 5'(PHY_BASE + g) &&
                  (rd_reg == 5'd1 || rd_reg == 5'd5))); // R9
    end

endmodule

bind mdio_duplex_resolver mdr_checker #(
    .NUM_PORTS (NUM_PORTS),
    .PHY_BASE  (PHY_BASE)
) u_mdr_checker (
    .clk         (clk),
    .rst         (rst),
    .en_q        (en_q),
    .rd_req      (rd_req),
    .rd_phy      (rd_phy),
    .rd_reg      (rd_reg),
    .rd_ack      (rd_ack),
    .rd_data     (rd_data),
    .duplex_full (duplex_full),
    .link_up     (link_up)
);

// File: tb/test_mdio_duplex_resolver.sv
module test_mdio_duplex_resolver;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  strap_en = 2'b00;
    logic        rd_req;
    logic [4:0]  rd_phy;
    logic [4:0]  rd_reg;
    logic        rd_ack = 1'b0;
    logic [15:0] rd_data = 16'h0;
    logic [1:0]  duplex_full;
    logic [1:0]  link_up;

    always #10 clk = ~clk;

    mdio_duplex_resolver i_mdio_duplex_resolver (
        .clk         (clk),
        .rst         (rst),
        .strap_en    (strap_en),
        .rd_req      (rd_req),
        .rd_phy      (rd_phy),
        .rd_reg      (rd_reg),
        .rd_ack      (rd_ack),
        .rd_data     (rd_data),
        .duplex_full (duplex_full),
        .link_up     (link_up)
    );

    logic [15:0] r1 [2];
    logic [15:0] r4 [2];
    logic [15:0] r5 [2];
    int rd1_cnt [2];
    int rd4_cnt [2];
    int req_cycles = 0;
    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // PHY responder: acknowledges after 0..2 wait cycles, drives on the falling edge
    logic       pending = 1'b0;
    logic [4:0] p_phy, p_reg;
    int         wcnt = 0;
    int         lat_seq = 0;
    int         last_stat_phy = 0;
    int         last_reg = 1;
    int         last_phy = 0;

    always @(negedge clk) begin
        if (rst) begin
            rd_ack = 1'b0;
            pending = 1'b0;
            last_stat_phy = 0;
            last_reg = 1;
            last_phy = 0;
        end else begin
            if (rd_req) req_cycles++;
            if (rd_ack) begin
                rd_ack = 1'b0;
            end else if (rd_req) begin
                if (!pending) begin
                    pending = 1'b1;
                    p_phy = rd_phy;
                    p_reg = rd_reg;
                    wcnt = lat_seq % 3;
                    lat_seq++;
                end else begin
                    chk("R10 address held while pending", {rd_phy, rd_reg}, {p_phy, p_reg});
                end
                if (wcnt == 0) begin
                    int idx;
                    pending = 1'b0;
                    idx = int'(rd_phy) - 1;
                    if (idx < 0 || idx > 1) begin
                        chk("R2 phy address", int'(rd_phy), 1);
                        idx = 0;
                    end
                    rd_ack = 1'b1;
                    case (rd_reg)
                        5'd1: begin
                            rd_data = r1[idx];
                            if (last_stat_phy != 0)
                                chk("R2 alternation", int'(rd_phy == 5'(last_stat_phy)), 0);
                            chk("R5 reg1 after reg1 or reg5", int'(last_reg == 1 || last_reg == 5), 1);
                            last_stat_phy = int'(rd_phy);
                            rd1_cnt[idx]++;
                        end
                        5'd4: begin
                            rd_data = r4[idx];
                            chk("R5 reg4 follows reg1 of same PHY",
                                int'(last_reg == 1 && last_phy == int'(rd_phy)), 1);
                            rd4_cnt[idx]++;
                        end
                        5'd5: begin
                            rd_data = r5[idx];
                            chk("R5 reg5 follows reg4 of same PHY",
                                int'(last_reg == 4 && last_phy == int'(rd_phy)), 1);
                        end
                        default: begin
                            rd_data = 16'h0;
                            chk("R2 register address", int'(rd_reg), 1);
                        end
                    endcase
                    last_reg = int'(rd_reg);
                    last_phy = int'(rd_phy);
                end else begin
                    wcnt--;
                end
            end
        end
    end

    task automatic report_and_end();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
            report_and_end();
        end
    end

    task automatic wait_stat(input int p, input int n);
        int tgt;
        tgt = rd1_cnt[p] + n;
        while (rd1_cnt[p] < tgt) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [1:0] s);
        @(posedge clk); #1;
        strap_en = s;
        rst = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        chk("R1 reset duplex", int'(duplex_full), 0);
        chk("R1 reset link", int'(link_up), 0);
        chk("R1 reset no request", int'(rd_req), 0);
        rst = 1'b0;
    endtask

    initial begin
        for (int p = 0; p < 2; p++) begin
            r1[p] = 16'h0024;
            r4[p] = 16'h01E1;
            r5[p] = 16'h01E1;
            rd1_cnt[p] = 0;
            rd4_cnt[p] = 0;
        end

        // disabled: only one strap bit high
        do_reset(2'b10);
        req_cycles = 0;
        repeat (60) @(posedge clk);
        #1;
        chk("R1 no requests when disabled", req_cycles, 0);
        chk("R1 duplex stays half when disabled", int'(duplex_full), 0);
        chk("R1 link stays down when disabled", int'(link_up), 0);

        // enabled, negotiation already done at first read
        do_reset(2'b11);
        wait_stat(0, 2);
        wait_stat(1, 2);
        chk("R7 resolve once after reset port0", rd4_cnt[0], 1);
        chk("R7 resolve once after reset port1", rd4_cnt[1], 1);
        chk("R7 duplex full after first resolve", int'(duplex_full), 3);
        chk("R4 link latched", int'(link_up), 3);

        begin
            int s;
            s = rd4_cnt[0] + rd4_cnt[1];
            wait_stat(0, 8);
            chk("R6 no re-resolve while done stays 1", rd4_cnt[0] + rd4_cnt[1], s);
        end

        // ability registers change without a new edge: duplex must hold
        r4[0] = 16'h0001;
        r5[0] = 16'h0001;
        wait_stat(0, 4);
        chk("R9 duplex unchanged without edge", int'(duplex_full[0]), 1);

        // port1: negotiation drops, then returns with 10BASE-T full only, link down
        r1[1] = 16'h0000;
        wait_stat(1, 2);
        chk("R3 port1 forced half", int'(duplex_full[1]), 0);
        chk("R4 port1 link down", int'(link_up[1]), 0);
        chk("R11 port0 untouched", int'(duplex_full[0]), 1);
        r4[1] = 16'h0041;
        r5[1] = 16'h0141;
        r1[1] = 16'h0020;
        wait_stat(1, 2);
        chk("R9 port1 10BASE-T full", int'(duplex_full[1]), 1);
        chk("R4 port1 link latched with done set", int'(link_up[1]), 0);

        // exhaustive sweep of ability bits 9..6 on both sides for port0
        for (int c = 0; c < 256; c++) begin
            logic [3:0]  fa, fb, both;
            logic [15:0] hi;
            int          exp_full, b4;
            fa = 4'(c);
            fb = 4'(c >> 4);
            both = fa & fb;
            hi = 16'((c * 37) << 10);
            r1[0] = (c % 2 == 1) ? 16'h0004 : 16'h0000;
            wait_stat(0, 2);
            chk("R3 port0 half while incomplete", int'(duplex_full[0]), 0);
            chk("R4 port0 link while incomplete", int'(link_up[0]), c % 2);
            b4 = rd4_cnt[0];
            r4[0] = hi | {6'b0, fa, 6'b000001};
            r5[0] = ~hi & {6'b0, fb, 6'b000001};
            r1[0] = 16'h0020 | (((c >> 1) % 2 == 1) ? 16'h0004 : 16'h0000);
            wait_stat(0, 2);
            // field bit0=reg bit6 10FD, bit1=bit7 TXHD, bit2=bit8 TXFD, bit3=bit9 T4
            exp_full = (both[2] || (!both[3] && !both[1] && both[0])) ? 1 : 0;
            chk("R8 priority resolution", int'(duplex_full[0]), exp_full);
            chk("R5 one resolve per edge", rd4_cnt[0] - b4, 1);
            chk("R11 port1 independent", int'(duplex_full[1]), 1);
        end

        report_and_end();
    end

endmodule